// File: doc/BRIEF.md
# Multi-Port Hardware Mutex Bank

This block holds a bank of hardware mutex words shared by several processors on one chip. Each processor has its own register port and its own small nonzero identifier. To try for a lock, a processor writes its identifier into that lock's word and then reads the word back. It owns the lock only if the value read back equals its identifier. Writing zero frees the lock.

A nonzero write to a word that already holds an owner is dropped, so the first claimant keeps the lock. A release is always accepted, whoever issues it. The software layer is expected to flag a release by a non-owner as a fault, but the hardware does not refuse it. Each lock word sits at a fixed stride above a base offset. Any access that does not land exactly on a lock word is harmless. A per-lock held vector lets surrounding logic watch lock state without bus traffic.

Top module: `hw_mutex_bank`

## Requirements
- R1: While reset is high and in the first cycle after it, every lock is free: lock_held is all zero and every read port returns zero.
- R2: Lock i sits at byte address BASE_OFS + i*SLOT_STRIDE. A nonzero write there to a free lock stores the written 32-bit value as the owner, and a later read of that address returns it.
- R3: A nonzero write to a lock that already holds a nonzero owner is ignored, so the stored owner is unchanged.
- R4: Writing zero to a lock frees it no matter which port writes and which owner is stored.
- R5: A read issued in cycle N returns its data on the read port in cycle N+1. In a cycle after one with no read on that port, the read port is zero. Reads never change any lock.
- R6: When several ports write the same lock in one cycle, only the lowest-numbered port's write takes effect. This holds whether that write is a claim or a release.
- R7: An address below BASE_OFS, not a whole multiple of SLOT_STRIDE above it, or beyond the last lock reads as zero and ignores writes.
- R8: lock_held[i] is 1 exactly when lock i stores a nonzero owner. It reflects a write in the cycle after that write.
- R9: Identifier 1 and the all-ones 32-bit identifier are both valid owners.
- R10: The locks are independent: a write to one lock never changes another.
- R11: A read in the same cycle as a write to the same lock returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | NUM_PORTS*ADDR_W | Byte address per port, port p in bits [p*ADDR_W +: ADDR_W] |
| bus_we | input | NUM_PORTS | Write strobe per port |
| bus_wdata | input | NUM_PORTS*DATA_W | Write data per port: owner ID, or zero to release |
| bus_re | input | NUM_PORTS | Read strobe per port |
| bus_rdata | output | NUM_PORTS*DATA_W | Registered read data per port, valid the cycle after the read |
| lock_held | output | NUM_LOCKS | Registered per-lock nonzero-owner flag |

## Verification
Every write takes effect at the next clock edge. Its result shows up on lock_held, and in any read issued in the following cycle, one cycle after the write. A read's data appears on its port one cycle after the read strobe. The bench drives one set of strobes at a falling edge. It computes the expected read data from its model as the model stood before that cycle's writes, applies the writes to the model, and then compares both read ports and the held vector at the next falling edge. Because of that ordering, a read and a write to the same lock in one cycle are judged on the old value. Directed cases cover same-cycle contention, release by a non-owner, misaligned and out-of-range addresses and extreme identifiers. They are followed by a seeded random run.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int unsigned MTX_WORD_W = 32;

  // Width of an index able to name n items (at least one bit).
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mtx_addr_dec.sv
// Maps a byte address onto a lock slot; flags anything that misses a slot.
module mtx_addr_dec #(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned NUM_LOCKS   = 32,
  parameter int unsigned BASE_OFS    = 256,
  parameter int unsigned SLOT_STRIDE = 8,
  localparam int unsigned IDX_W      = mtx_pkg::idx_bits(NUM_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  slot
);
  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE_OFS);
  localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(SLOT_STRIDE);
  localparam logic [ADDR_W-1:0] COUNT_A  = ADDR_W'(NUM_LOCKS);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] quo;
  logic [ADDR_W-1:0] rem;

  always_comb begin
    rel  = addr - BASE_A;
    quo  = rel / STRIDE_A;
    rem  = rel % STRIDE_A;
    hit  = (addr >= BASE_A) && (rem == '0) && (quo < COUNT_A);
    slot = quo[IDX_W-1:0];
  end
endmodule

// File: rtl/mtx_port.sv
// One processor port: decodes its address and registers its read data.
module mtx_port #(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_LOCKS   = 32,
  parameter int unsigned BASE_OFS    = 256,
  parameter int unsigned SLOT_STRIDE = 8,
  localparam int unsigned IDX_W      = mtx_pkg::idx_bits(NUM_LOCKS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              re,
  input  logic [NUM_LOCKS-1:0][DATA_W-1:0]  owner,
  output logic                              hit,
  output logic [IDX_W-1:0]                  slot,
  output logic [DATA_W-1:0]                 rdata
);
  logic [DATA_W-1:0] rdata_d;

  mtx_addr_dec #(
    .ADDR_W     (ADDR_W),
    .NUM_LOCKS  (NUM_LOCKS),
    .BASE_OFS   (BASE_OFS),
    .SLOT_STRIDE(SLOT_STRIDE)
  ) u_dec (
    .addr(addr),
    .hit (hit),
    .slot(slot)
  );

  always_comb begin
    rdata_d = '0;
    if (re && hit) rdata_d = owner[slot];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rdata_d;
  end
endmodule

// File: rtl/mtx_lock_cell.sv
// One lock word: lowest-numbered requesting port wins, claims only land on a free word.
module mtx_lock_cell #(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PORTS-1:0]          req,
  input  logic [NUM_PORTS*DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]             owner,
  output logic                          held
);
  logic              sel_vld;
  logic [DATA_W-1:0] sel_val;
  logic [DATA_W-1:0] owner_d;

  always_comb begin
    sel_vld = 1'b0;
    sel_val = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (req[p]) begin
        sel_vld = 1'b1;
        sel_val = wdata[p*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    owner_d = owner;
    if (sel_vld) begin
      if (sel_val == '0)      owner_d = '0;
      else if (owner == '0)   owner_d = sel_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner <= '0;
      held  <= 1'b0;
    end else begin
      owner <= owner_d;
      held  <= (owner_d != '0);
    end
  end
endmodule

// File: rtl/hw_mutex_bank.sv
module hw_mutex_bank #(
  parameter int unsigned NUM_PORTS   = 2,
  parameter int unsigned NUM_LOCKS   = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = mtx_pkg::MTX_WORD_W,
  parameter int unsigned BASE_OFS    = 256,
  parameter int unsigned SLOT_STRIDE = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_PORTS*ADDR_W-1:0]  bus_addr,
  input  logic [NUM_PORTS-1:0]         bus_we,
  input  logic [NUM_PORTS*DATA_W-1:0]  bus_wdata,
  input  logic [NUM_PORTS-1:0]         bus_re,
  output logic [NUM_PORTS*DATA_W-1:0]  bus_rdata,
  output logic [NUM_LOCKS-1:0]         lock_held
);
  localparam int unsigned IDX_W = mtx_pkg::idx_bits(NUM_LOCKS);

  logic [NUM_LOCKS-1:0][DATA_W-1:0] owner_q;
  logic [NUM_PORTS-1:0]             port_hit;
  logic [NUM_PORTS-1:0][IDX_W-1:0]  port_slot;
  logic [NUM_LOCKS-1:0][NUM_PORTS-1:0] lock_req;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mtx_port #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .NUM_LOCKS  (NUM_LOCKS),
      .BASE_OFS   (BASE_OFS),
      .SLOT_STRIDE(SLOT_STRIDE)
    ) u_port (
      .clk  (clk),
      .rst  (rst),
      .addr (bus_addr[p*ADDR_W +: ADDR_W]),
      .re   (bus_re[p]),
      .owner(owner_q),
      .hit  (port_hit[p]),
      .slot (port_slot[p]),
      .rdata(bus_rdata[p*DATA_W +: DATA_W])
    );
  end

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_req
      assign lock_req[l][p] = bus_we[p] && port_hit[p] &&
                              (port_slot[p] == IDX_W'(l));
    end

    mtx_lock_cell #(
      .NUM_PORTS(NUM_PORTS),
      .DATA_W   (DATA_W)
    ) u_cell (
      .clk  (clk),
      .rst  (rst),
      .req  (lock_req[l]),
      .wdata(bus_wdata),
      .owner(owner_q[l]),
      .held (lock_held[l])
    );
  end
endmodule

// File: rtl/hw_mutex_bank_chk.sv
module hw_mutex_bank_chk #(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned DATA_W    = 32
) (
  input logic                                clk,
  input logic                                rst,
  input logic [NUM_PORTS-1:0]                bus_we,
  input logic [NUM_PORTS*DATA_W-1:0]         bus_wdata,
  input logic [NUM_PORTS-1:0]                bus_re,
  input logic [NUM_PORTS*DATA_W-1:0]         bus_rdata,
  input logic [NUM_LOCKS-1:0]                lock_held,
  input logic [NUM_LOCKS-1:0][DATA_W-1:0]    owner
);
  function automatic logic from_some_port(input logic [DATA_W-1:0] v,
                                          input logic [NUM_PORTS*DATA_W-1:0] wd);
    logic m;
    m = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (wd[p*DATA_W +: DATA_W] == v) m = 1'b1;
    return m;
  endfunction

  // R1: reset leaves every lock free and every read port quiet
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (lock_held == '0 && bus_rdata == '0));

  // R8: held flags move only when some port wrote in the previous cycle
  a_r8_held_needs_write: assert property (@(posedge clk) disable iff (rst)
    !(|bus_we) |=> $stable(lock_held));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pchk
    // R5: no read strobe means zero data on the next cycle
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !bus_re[p] |=> (bus_rdata[p*DATA_W +: DATA_W] == '0));
  end

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lchk
    // R3: a held owner either stays or becomes free, never another ID
    a_r3_owner_sticky: assert property (@(posedge clk) disable iff (rst)
      (owner[l] != '0) |=> (owner[l] == $past(owner[l]) || owner[l] == '0));
    // R2: a free lock can only take a value that some port wrote
    a_r2_claim_source: assert property (@(posedge clk) disable iff (rst)
      (owner[l] == '0) |=> (owner[l] == '0 || from_some_port(owner[l], $past(bus_wdata))));
    // R8: held flag agrees with the stored owner
    a_r8_held_matches: assert property (@(posedge clk) disable iff (rst)
      lock_held[l] == (owner[l] != '0));
  end
endmodule

bind hw_mutex_bank hw_mutex_bank_chk #(
  .NUM_PORTS(NUM_PORTS),
  .NUM_LOCKS(NUM_LOCKS),
  .DATA_W   (DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_re   (bus_re),
  .bus_rdata(bus_rdata),
  .lock_held(lock_held),
  .owner    (owner_q)
);

// File: tb/test_hw_mutex_bank.sv
module test_hw_mutex_bank;
  localparam int NP  = 2;
  localparam int NL  = 32;
  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam int BASE = 256;
  localparam int STR  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP*AW-1:0] bus_addr  = '0;
  logic [NP-1:0]    bus_we    = '0;
  logic [NP*DW-1:0] bus_wdata = '0;
  logic [NP-1:0]    bus_re    = '0;
  logic [NP*DW-1:0] bus_rdata;
  logic [NL-1:0]    lock_held;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [DW-1:0] mdl [NL];

  always #5 clk = ~clk;

  hw_mutex_bank #(
    .NUM_PORTS(NP), .NUM_LOCKS(NL), .ADDR_W(AW), .DATA_W(DW),
    .BASE_OFS(BASE), .SLOT_STRIDE(STR)
  ) i_hw_mutex_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .lock_held(lock_held)
  );

  function automatic int slot_addr(input int i);
    return BASE + i * STR;
  endfunction

  function automatic bit addr_ok(input int a);
    return (a >= BASE) && (((a - BASE) % STR) == 0) && (((a - BASE) / STR) < NL);
  endfunction

  function automatic int addr_idx(input int a);
    return (a - BASE) / STR;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_op(input int p, input int a, input bit we, input logic [DW-1:0] wd, input bit re);
    bus_addr[p*AW +: AW] = AW'(a);
    bus_we[p]            = we;
    bus_wdata[p*DW +: DW] = wd;
    bus_re[p]            = re;
  endtask

  // Called at a falling edge with strobes set; checks at the next falling edge.
  task automatic step(input string tag_rd, input string tag_held);
    logic [DW-1:0] exp_rd [NP];
    bit taken [NL];
    logic [NL-1:0] exp_held;
    for (int p = 0; p < NP; p++) begin
      int a;
      a = int'(bus_addr[p*AW +: AW]);
      exp_rd[p] = (bus_re[p] && addr_ok(a)) ? mdl[addr_idx(a)] : '0;
    end
    for (int i = 0; i < NL; i++) taken[i] = 0;
    for (int p = 0; p < NP; p++) begin
      int a;
      logic [DW-1:0] wd;
      a  = int'(bus_addr[p*AW +: AW]);
      wd = bus_wdata[p*DW +: DW];
      if (bus_we[p] && addr_ok(a) && !taken[addr_idx(a)]) begin
        taken[addr_idx(a)] = 1;
        if (wd == '0) mdl[addr_idx(a)] = '0;
        else if (mdl[addr_idx(a)] == '0) mdl[addr_idx(a)] = wd;
      end
    end
    for (int i = 0; i < NL; i++) exp_held[i] = (mdl[i] != '0);
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      check(tag_rd, bus_rdata[p*DW +: DW], exp_rd[p]);
    check(tag_held, DW'(lock_held), DW'(exp_held));
    bus_we = '0;
    bus_re = '0;
  endtask

  task automatic rd(input int p, input int a, input string tag);
    set_op(p, a, 0, '0, 1);
    step(tag, tag);
  endtask

  initial begin
    int seed;
    for (int i = 0; i < NL; i++) mdl[i] = '0;
    seed = int'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    check("R1", DW'(lock_held), '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", DW'(lock_held), '0);
    check("R1", bus_rdata[DW-1:0], '0);
    for (int i = 0; i < NL; i++) rd(i % NP, slot_addr(i), "R1");

    // R9 / R2: claim with ID 1 and read back
    set_op(0, slot_addr(3), 1, 32'd1, 0); step("R2", "R9");
    rd(0, slot_addr(3), "R2");
    // R3: second claimant is ignored
    set_op(1, slot_addr(3), 1, 32'd5, 0); step("R3", "R3");
    rd(1, slot_addr(3), "R3");
    // R4: release by a non-owner port is accepted
    set_op(1, slot_addr(3), 1, 32'd0, 0); step("R4", "R4");
    rd(0, slot_addr(3), "R4");
    // R6: simultaneous claims, port 0 wins
    set_op(0, slot_addr(7), 1, 32'd2, 0); set_op(1, slot_addr(7), 1, 32'd9, 0); step("R6", "R6");
    rd(1, slot_addr(7), "R6");
    // R6: port 0 release beats port 1 claim
    set_op(0, slot_addr(7), 1, 32'd0, 0); set_op(1, slot_addr(7), 1, 32'd4, 0); step("R6", "R6");
    rd(0, slot_addr(7), "R6");
    // R6: port 0 claim beats port 1 release
    set_op(0, slot_addr(7), 1, 32'd6, 0); set_op(1, slot_addr(7), 1, 32'd0, 0); step("R6", "R6");
    rd(0, slot_addr(7), "R6");
    // R7: misaligned, below base, beyond last lock
    set_op(0, slot_addr(5) + 1, 1, 32'd7, 0); step("R7", "R7");
    rd(0, slot_addr(5), "R7");
    rd(1, slot_addr(7) + 4, "R7");
    set_op(0, BASE - STR, 1, 32'd7, 1); step("R7", "R7");
    set_op(1, slot_addr(NL), 1, 32'd7, 1); step("R7", "R7");
    // R9 / R10: all-ones owner on last lock, neighbours untouched
    set_op(0, slot_addr(NL - 1), 1, 32'hFFFF_FFFF, 0); step("R9", "R10");
    rd(1, slot_addr(NL - 1), "R9");
    rd(0, slot_addr(NL - 2), "R10");
    rd(0, slot_addr(0), "R10");
    // R11: read collides with write to same lock
    set_op(0, slot_addr(10), 1, 32'd3, 0); set_op(1, slot_addr(10), 0, '0, 1); step("R11", "R8");
    rd(1, slot_addr(10), "R11");
    // R5: idle cycle gives zero; repeated reads are side-effect free
    step("R5", "R5");
    rd(0, slot_addr(10), "R5");
    rd(0, slot_addr(10), "R5");

    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < NP; p++) begin
        int a;
        logic [DW-1:0] wd;
        int k;
        a = ($urandom % 10 < 8) ? slot_addr(int'($urandom % NL)) : int'($urandom % (1 << AW));
        k = int'($urandom % 5);
        wd = (k == 0) ? 32'd0 : (k == 1) ? 32'd1 : (k == 2) ? 32'd2 :
             (k == 3) ? 32'd7 : 32'hFFFF_FFFF;
        set_op(p, a, bit'($urandom % 2), wd, bit'($urandom % 2));
      end
      step("R5", "R10");
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule